// File: doc/BRIEF.md
# PCI Memory-Target Burst Address Sequencer

This block produces the local 32-bit word address for each data phase of a burst in which the chip is a PCI memory target. When the address phase is strobed, it captures the bus address and the command. The two lowest address bits and the command together select the ordering of the burst. After that, the held address moves forward by one word each time a data phase completes. The bus handshake is reduced to a single completion pulse, one for every phase that finishes.

The ordering can be plain linear incrementing, or a cache-line wrap on reads. A wrap starts at the critical 64-bit word, wraps inside the aligned line, and asks for a disconnect after one full line has been transferred. If a memory command arrives with the reserved low-bit pattern, the block asks for a disconnect after the first phase. Non-memory commands do not enter the burst logic: their address is held unchanged. The bus interface uses the last-phase flag to present STOP with the final transfer. It uses the disconnect request to refuse any further phases. The low address bits still feed the address-phase parity, but that logic sits outside this block.

Top module: `pci_burst_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `word_addr` is zero and `last_phase` and `disc_req` are low.
- R2: An `addr_phase` cycle loads `ad_in[31:2]` into `word_addr`, which shows the new value on the next cycle. This holds for every mode except the wrap of R5.
- R3: The memory commands are 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111, and of these the reads are 4'b0110, 4'b1100 and 4'b1110. Any other command holds `word_addr` at the loaded value whatever `phase_done` does, and never raises `last_phase` or `disc_req`.
- R4: A memory command with `ad_in[1:0]`=00 gives linear order. `word_addr` goes up by one in the cycle after each `phase_done`, holds when no phase completes, and never raises `last_phase` or `disc_req`.
- R5: A memory read with `ad_in[1:0]`=10 starts the wrap at the critical 64-bit word. The starting `word_addr` is `ad_in[31:3]` followed by a zero bit.
- R6: In wrap mode only the low log2(LINE_BYTES/4) bits of `word_addr` count up. They go from their maximum back to zero, and the upper bits stay fixed.
- R7: In wrap mode, `last_phase` is high during phase number LINE_BYTES/4, counted from one. `disc_req` rises in the cycle after that phase completes and stays high until the next address phase. Once it is high, further `phase_done` pulses leave `word_addr` unchanged.
- R8: A memory command with `ad_in[0]`=1 is the reserved one-phase mode. `last_phase` is high during the first phase. When that phase completes, `word_addr` advances once and `disc_req` rises in the next cycle. After that the address is frozen.
- R9: A memory write with `ad_in[1:0]`=10 is treated as linear order and does not wrap.
- R10: An `addr_phase` clears `disc_req` and restarts the sequence. If `phase_done` is high in the same cycle, `addr_phase` takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | High for the one cycle of the address phase |
| ad_in | input | ADDR_W (32) | Address/data bus sampled during the address phase |
| cmd | input | 4 | Bus command sampled during the address phase |
| phase_done | input | 1 | A data phase completed this cycle (initiator and target ready) |
| word_addr | output | ADDR_W-2 (30) | Local word address of the current data phase |
| last_phase | output | 1 | The current data phase is the final one the block permits |
| disc_req | output | 1 | Disconnect request; no further phases are accepted |

## Verification
The bench builds the block with its default 32-byte line and 64-bit critical word. This gives an eight-phase wrap whose critical word can start at any of the four 64-bit positions in the line. Short random bursts are therefore enough to reach the wrap-around point from every start offset, as well as the disconnect that follows. A 30-bit word address allows a linear burst to cross line boundaries freely, which separates the R9 write case from a wrap. The random command mix includes I/O and configuration codes alongside all five memory commands and all four low-bit patterns.

// File: rtl/pbas_pkg.sv
package pbas_pkg;

  typedef enum logic [1:0] {
    BM_PASS    = 2'd0,
    BM_LINEAR  = 2'd1,
    BM_WRAP    = 2'd2,
    BM_ONESHOT = 2'd3
  } bmode_e;

  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  function automatic logic cmd_is_mem(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
           (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
  endfunction

endpackage

// File: rtl/pbas_decode.sv
module pbas_decode
  import pbas_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic [1:0] ad_lo,
  output bmode_e     mode
);

  always_comb begin
    if (!cmd_is_mem(cmd)) begin
      mode = BM_PASS;
    end else if (ad_lo[0]) begin
      mode = BM_ONESHOT;
    end else if (ad_lo[1] && cmd_is_read(cmd)) begin
      mode = BM_WRAP;
    end else begin
      mode = BM_LINEAR;
    end
  end

endmodule

// File: rtl/pbas_ctrl.sv
module pbas_ctrl
  import pbas_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int CNT_W     = $clog2(LINE_WORDS) + 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  bmode_e mode_in,
  input  logic   phase_done,
  output bmode_e mode_q,
  output logic   step_en,
  output logic   last_phase,
  output logic   disc_req
);

  bmode_e             mode_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               disc_q, disc_d;
  logic               ce;

  always_comb begin
    step_en    = phase_done && !load && (mode_q != BM_PASS) && !disc_q;
    last_phase = !disc_q &&
                 (((mode_q == BM_WRAP) && (cnt_q == CNT_W'(LINE_WORDS - 1))) ||
                  ((mode_q == BM_ONESHOT) && (cnt_q == '0)));
    ce     = load || step_en;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    disc_d = disc_q;
    if (load) begin
      mode_d = mode_in;
      cnt_d  = '0;
      disc_d = 1'b0;
    end else if (step_en) begin
      cnt_d  = cnt_q + CNT_W'(1);
      disc_d = last_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BM_PASS;
      cnt_q  <= '0;
      disc_q <= 1'b0;
    end else if (ce) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      disc_q <= disc_d;
    end
  end

  assign disc_req = disc_q;

endmodule

// File: rtl/pbas_addr.sv
module pbas_addr
  import pbas_pkg::*;
#(
  parameter int WA_W       = 30,
  parameter int LINE_WORDS = 8,
  parameter int CRIT_WORDS = 2,
  localparam int OFS_W     = $clog2(LINE_WORDS),
  localparam int CRIT_W    = $clog2(CRIT_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WA_W-1:0] ad_word,
  input  bmode_e          mode_in,
  input  bmode_e          mode_q,
  input  logic            step_en,
  output logic [WA_W-1:0] word_q
);

  logic [WA_W-1:0]  crit_word;
  logic [WA_W-1:0]  start_word;
  logic [WA_W-1:0]  word_d;
  logic [OFS_W-1:0] ofs_inc;
  logic             ce;

  generate
    if (CRIT_W == 0) begin : g_crit_word
      assign crit_word = ad_word;
    end else begin : g_crit_multi
      assign crit_word = {ad_word[WA_W-1:CRIT_W], {CRIT_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    start_word = (mode_in == BM_WRAP) ? crit_word : ad_word;
    ofs_inc    = word_q[OFS_W-1:0] + OFS_W'(1);
    ce         = load || step_en;
    word_d     = word_q;
    if (load) begin
      word_d = start_word;
    end else if (step_en) begin
      if (mode_q == BM_WRAP) begin
        word_d = {word_q[WA_W-1:OFS_W], ofs_inc};
      end else begin
        word_d = word_q + WA_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (ce) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/pci_burst_seq.sv
module pci_burst_seq
  import pbas_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int CRIT_BYTES = 8,
  localparam int WA_W       = ADDR_W - 2,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int CRIT_WORDS = CRIT_BYTES / 4,
  localparam int OFS_W      = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [3:0]        cmd,
  input  logic              phase_done,
  output logic [WA_W-1:0]   word_addr,
  output logic              last_phase,
  output logic              disc_req
);

  bmode_e mode_new;
  bmode_e mode_q;
  logic   step_en;

  pbas_decode u_decode (
    .cmd   (cmd),
    .ad_lo (ad_in[1:0]),
    .mode  (mode_new)
  );

  pbas_ctrl #(
    .LINE_WORDS (LINE_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (addr_phase),
    .mode_in    (mode_new),
    .phase_done (phase_done),
    .mode_q     (mode_q),
    .step_en    (step_en),
    .last_phase (last_phase),
    .disc_req   (disc_req)
  );

  pbas_addr #(
    .WA_W       (WA_W),
    .LINE_WORDS (LINE_WORDS),
    .CRIT_WORDS (CRIT_WORDS)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (addr_phase),
    .ad_word (ad_in[ADDR_W-1:2]),
    .mode_in (mode_new),
    .mode_q  (mode_q),
    .step_en (step_en),
    .word_q  (word_addr)
  );

endmodule

// File: rtl/pbas_chk.sv
module pbas_chk
  import pbas_pkg::*;
#(
  parameter int WA_W  = 30,
  parameter int OFS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_phase,
  input logic            phase_done,
  input logic [WA_W-1:0] word_addr,
  input logic            last_phase,
  input logic            disc_req,
  input bmode_e          mode_q
);

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && phase_done && mode_q == BM_LINEAR)
      |=> (word_addr == $past(word_addr) + WA_W'(1)));

  // R4
  hold_without_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && !phase_done) |=> $stable(word_addr));

  // R6
  wrap_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && mode_q == BM_WRAP)
      |=> (word_addr[WA_W-1:OFS_W] == $past(word_addr[WA_W-1:OFS_W])));

  // R7
  disc_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_req) |-> $past(last_phase && phase_done));

  // R10
  disc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !disc_req);

  // R7
  no_last_when_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |-> !last_phase);

  // R3
  pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BM_PASS) |-> (!last_phase && !disc_req));

endmodule

bind pci_burst_seq pbas_chk #(
  .WA_W  (WA_W),
  .OFS_W (OFS_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_phase (addr_phase),
  .phase_done (phase_done),
  .word_addr  (word_addr),
  .last_phase (last_phase),
  .disc_req   (disc_req),
  .mode_q     (mode_q)
);

// File: tb/test_pci_burst_seq.sv
module test_pci_burst_seq;

  localparam int LW = 8;

  logic        clk;
  logic        rst_n;
  logic        addr_phase;
  logic [31:0] ad_in;
  logic [3:0]  cmd;
  logic        phase_done;
  logic [29:0] word_addr;
  logic        last_phase;
  logic        disc_req;

  int n_tests = 0;
  int n_fail  = 0;

  int          m_mode;
  logic [29:0] m_start;
  int          m_n;

  pci_burst_seq i_pci_burst_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .ad_in      (ad_in),
    .cmd        (cmd),
    .phase_done (phase_done),
    .word_addr  (word_addr),
    .last_phase (last_phase),
    .disc_req   (disc_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // mode codes: 0 pass, 1 linear, 2 wrap, 3 one-phase
  function automatic int exp_mode(logic [3:0] c, logic [1:0] lo);
    bit mem, rd;
    mem = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    rd  = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    if (!mem) return 0;
    if (lo[0]) return 3;
    if (lo[1] && rd) return 2;
    return 1;
  endfunction

  function automatic logic [29:0] exp_addr(int md, logic [29:0] s, int n);
    int ofs;
    case (md)
      0: return s;
      1: return s + 30'(n);
      2: begin
        ofs = int'(s % LW);
        return (s - 30'(ofs)) + 30'((ofs + n) % LW);
      end
      default: return s + 30'((n > 0) ? 1 : 0);
    endcase
  endfunction

  function automatic bit exp_disc(int md, int n);
    return ((md == 2) && (n >= LW)) || ((md == 3) && (n >= 1));
  endfunction

  function automatic bit exp_last(int md, int n);
    return !exp_disc(md, n) && (((md == 2) && (n == LW - 1)) || ((md == 3) && (n == 0)));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [29:0] ea;
    ea = exp_addr(m_mode, m_start, m_n);
    chk(word_addr == ea, req, "word_addr", longint'(word_addr), longint'(ea));
    chk(last_phase == exp_last(m_mode, m_n), req, "last_phase",
        longint'(last_phase), longint'(exp_last(m_mode, m_n)));
    chk(disc_req == exp_disc(m_mode, m_n), req, "disc_req",
        longint'(disc_req), longint'(exp_disc(m_mode, m_n)));
  endtask

  // called just after a falling edge; drives, clocks, updates model, checks
  task automatic step(bit ap, logic [31:0] ad, logic [3:0] c, bit pd, string req);
    addr_phase = ap;
    ad_in      = ad;
    cmd        = c;
    phase_done = pd;
    @(posedge clk);
    #1;
    if (ap) begin
      m_mode  = exp_mode(c, ad[1:0]);
      m_start = (m_mode == 2) ? {ad[31:3], 1'b0} : ad[31:2];
      m_n     = 0;
    end else if (pd && (m_mode != 0) && !exp_disc(m_mode, m_n)) begin
      m_n++;
    end
    @(negedge clk);
    check_all(req);
  endtask

  function automatic string tag_of(int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [3:0] cmds [10];
    int dummy;
    cmds = '{4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'h2, 4'h3, 4'hA, 4'hB, 4'h6};
    dummy = $urandom(32'h5eed_1234);
    m_mode = 0; m_start = '0; m_n = 0;
    rst_n = 1'b0; addr_phase = 1'b0; ad_in = '0; cmd = '0; phase_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R5 R6 R7: wrap read, critical 64-bit word at word 7 of the line -> start 6
    step(1'b1, 32'h0000_101E, 4'h6, 1'b0, "R5");
    chk(word_addr == 30'h406, "R5", "crit start", longint'(word_addr), 30'h406);
    for (int i = 0; i < LW; i++) step(1'b0, '0, 4'h0, 1'b1, "R6");
    chk(disc_req == 1'b1, "R7", "disc after line", longint'(disc_req), 1);
    chk(word_addr == 30'h406, "R7", "wrapped back", longint'(word_addr), 30'h406);
    step(1'b0, '0, 4'h0, 1'b1, "R7");
    step(1'b0, '0, 4'h0, 1'b1, "R7");

    // R10: new address phase with a simultaneous phase_done; R2 load
    step(1'b1, 32'h0000_201C, 4'h7, 1'b1, "R10");
    chk(word_addr == 30'h807, "R2", "load", longint'(word_addr), 30'h807);
    chk(disc_req == 1'b0, "R10", "disc cleared", longint'(disc_req), 0);

    // R9: write with wrap pattern runs linear across the line edge
    step(1'b1, 32'h0000_201E, 4'h7, 1'b0, "R9");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 4'h0, 1'b1, "R9");
    chk(word_addr == 30'h80A, "R9", "no wrap", longint'(word_addr), 30'h80A);

    // R8: reserved pattern
    step(1'b1, 32'h0000_3005, 4'hC, 1'b0, "R8");
    chk(last_phase == 1'b1, "R8", "last first", longint'(last_phase), 1);
    step(1'b0, '0, 4'h0, 1'b1, "R8");
    step(1'b0, '0, 4'h0, 1'b1, "R8");
    chk(word_addr == 30'hC02, "R8", "frozen", longint'(word_addr), 30'hC02);

    // R3: I/O command holds address
    step(1'b1, 32'h1234_5678, 4'h2, 1'b0, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 4'h0, 1'b1, "R3");
    chk(word_addr == 30'h048D159E, "R3", "held", longint'(word_addr), 30'h048D159E);

    // R4: linear with gaps
    step(1'b1, 32'hFFFF_FFF8, 4'hE, 1'b0, "R4");
    step(1'b0, '0, 4'h0, 1'b0, "R4");
    step(1'b0, '0, 4'h0, 1'b1, "R4");
    step(1'b0, '0, 4'h0, 1'b1, "R4");

    // random bursts
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a;
      logic [3:0]  c;
      int len;
      a   = $urandom;
      c   = cmds[$urandom_range(0, 9)];
      len = $urandom_range(1, 12);
      step(1'b1, a, c, ($urandom_range(0, 3) == 0), "R2");
      for (int k = 0; k < len; k++)
        step(1'b0, $urandom, 4'($urandom), ($urandom_range(0, 9) < 7), tag_of(m_mode));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule